// File: doc/BRIEF.md
# Iterative AES-128 Encryption Core

This block encrypts a single 128-bit plaintext block under a 128-bit key. It computes one complete cipher round per clock and derives each round key in the same cycle as the round that uses it. The key schedule is never stored.

Control runs on two plain pins, kept apart from the data and key buses. A one-cycle `start` launches a job, and `done` reports that the ciphertext on `data_out` is final. No command words or headers travel on the buses.

The block gives no back-pressure. A `start` that arrives while a job is running is dropped, and the caller may only launch a job while `done` is high or before the first job. The result stays on the output until the next accepted `start`, so a consumer can read it at any time.

Top module: `aes_iter_core`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first `start`, `done` is 0 and `data_out` is all zeros.
- R2: With `done` low and no job running, the core stays idle until `start` is sampled high. `data_in` and `key_in` are captured only on the edge that samples `start`, and later changes to them do not affect the result.
- R3: `done` is low on the first 9 rising edges after the capture edge and high after the 10th. This makes 11 clock cycles per block, counting the capture cycle that performs the initial key addition.
- R4: For key 000102030405060708090a0b0c0d0e0f and plaintext 00112233445566778899aabbccddeeff, the output is 69c4e0d86a7b0430d8cdb78070b4c55a.
- R5: For any key and plaintext, `data_out` equals the standard AES-128 ciphertext once `done` is high. This covers the round-constant sequence 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36 and a tenth round without column mixing.
- R6: A `start` sampled while a job is running is ignored, and both the result and its timing are unchanged.
- R7: While `done` is high and `start` is low, `done` stays high and `data_out` holds its value. A `start` sampled while `done` is high launches a new job, and `done` is low after that edge.
- R8: All buses are indexed 0 to 127, with bit 0 the most significant bit. Byte k occupies bits 8k to 8k+7, and byte k sits at row k mod 4, column k div 4 of the cipher state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a job when no job is running |
| data_in | input | 128 | Plaintext block, bit 0 is the MSB |
| key_in | input | 128 | Cipher key, bit 0 is the MSB |
| data_out | output | 128 | Ciphertext, valid while `done` is high |
| done | output | 1 | Result valid; held high until the next accepted `start` |

## Verification
The only result the block produces is the ciphertext, with `done` rising after the 10th rising edge that follows the edge sampling `start`. The bench drives inputs on falling edges and counts rising edges from the capture edge. It samples at the falling edge after edge 9, where `done` must still be low, and at the falling edge after edge 10, where `done` must be high and `data_out` must equal an independently computed cipher. `start` pulses injected during a job, and bus changes made right after capture, are timed so they are sampled only while the job runs. `done` must fall at the falling edge directly after each new capture edge.

// File: rtl/aes_iter_pkg.sv
package aes_iter_pkg;
  localparam int BLK_W      = 128;
  localparam int NUM_BYTES  = BLK_W / 8;
  localparam int NUM_ROUNDS = 10;

  typedef logic [7:0] byte_t;
  typedef logic [0:NUM_BYTES-1][7:0] block_t;

  function automatic byte_t xtime(byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gf_mul(byte_t a, byte_t b);
    byte_t acc, aa, bb;
    acc = 8'h00;
    aa  = a;
    bb  = b;
    for (int i = 0; i < 8; i++) begin
      if (bb[0]) acc = acc ^ aa;
      aa = xtime(aa);
      bb = {1'b0, bb[7:1]};
    end
    return acc;
  endfunction

  // multiplicative inverse as x^254, then the affine map
  function automatic byte_t sub_byte(byte_t x);
    byte_t pw, inv, y;
    pw  = x;
    inv = 8'h01;
    for (int k = 1; k < 8; k++) begin
      pw  = gf_mul(pw, pw);
      inv = gf_mul(inv, pw);
    end
    y = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
            ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    return y;
  endfunction
endpackage

// File: rtl/aes_sbox.sv
module aes_sbox
  import aes_iter_pkg::*;
(
  input  byte_t a,
  output byte_t y
);
  assign y = sub_byte(a);
endmodule

// File: rtl/aes_round.sv
module aes_round
  import aes_iter_pkg::*;
(
  input  block_t st,
  input  block_t rk,
  input  logic   last_rnd,
  output block_t nx
);
  block_t sb, sh;

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_sub
    aes_sbox u_sb (.a(st[i]), .y(sb[i]));
  end

  // row r of column c takes the byte from column (c+r) mod 4
  for (genvar c = 0; c < 4; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      assign sh[4*c + r] = sb[4*((c + r) % 4) + r];
    end

    byte_t a0, a1, a2, a3;
    byte_t m0, m1, m2, m3;
    assign a0 = sh[4*c];
    assign a1 = sh[4*c + 1];
    assign a2 = sh[4*c + 2];
    assign a3 = sh[4*c + 3];
    assign m0 = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
    assign m1 = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
    assign m2 = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
    assign m3 = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);

    assign nx[4*c]     = (last_rnd ? a0 : m0) ^ rk[4*c];
    assign nx[4*c + 1] = (last_rnd ? a1 : m1) ^ rk[4*c + 1];
    assign nx[4*c + 2] = (last_rnd ? a2 : m2) ^ rk[4*c + 2];
    assign nx[4*c + 3] = (last_rnd ? a3 : m3) ^ rk[4*c + 3];
  end
endmodule

// File: rtl/aes_key_step.sv
module aes_key_step
  import aes_iter_pkg::*;
(
  input  block_t rk,
  input  byte_t  rcon,
  output block_t nk
);
  byte_t t0, t1, t2, t3;
  byte_t s0;

  // rotated last word through the S-box
  aes_sbox u_s0 (.a(rk[13]), .y(s0));
  aes_sbox u_s1 (.a(rk[14]), .y(t1));
  aes_sbox u_s2 (.a(rk[15]), .y(t2));
  aes_sbox u_s3 (.a(rk[12]), .y(t3));
  assign t0 = s0 ^ rcon;

  always_comb begin
    nk[0] = rk[0] ^ t0;
    nk[1] = rk[1] ^ t1;
    nk[2] = rk[2] ^ t2;
    nk[3] = rk[3] ^ t3;
    for (int j = 4; j < NUM_BYTES; j++) nk[j] = rk[j] ^ nk[j-4];
  end
endmodule

// File: rtl/aes_ctrl.sv
module aes_ctrl
  import aes_iter_pkg::*;
#(
  parameter int NR = NUM_ROUNDS
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  output logic  load,
  output logic  step,
  output logic  last_rnd,
  output byte_t rcon,
  output logic  done
);
  localparam int RW = $clog2(NR + 1);
  localparam logic [RW-1:0] RND_LAST = RW'(NR);

  logic          busy_q;
  logic [RW-1:0] rnd_q;

  assign load     = start && !busy_q;
  assign step     = busy_q;
  assign last_rnd = (rnd_q == RND_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done   <= 1'b0;
      rnd_q  <= '0;
      rcon   <= 8'h00;
    end else if (load) begin
      busy_q <= 1'b1;
      done   <= 1'b0;
      rnd_q  <= RW'(1);
      rcon   <= 8'h01;
    end else if (busy_q) begin
      rnd_q <= rnd_q + 1'b1;
      rcon  <= xtime(rcon);
      if (last_rnd) begin
        busy_q <= 1'b0;
        done   <= 1'b1;
      end
    end
  end

  p_idle_until_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && !start |=> !busy_q);
  p_no_done_while_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !done);
  p_done_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && last_rnd |=> done && !busy_q);
  p_round_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rnd_q >= RW'(1)) && (rnd_q <= RND_LAST));
  p_start_ignored_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start && !last_rnd |=> busy_q && rnd_q == $past(rnd_q) + 1'b1);
  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);
  p_restart_drops_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && start |=> !done && busy_q);
endmodule

// File: rtl/aes_iter_core.sv
module aes_iter_core
  import aes_iter_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [0:127] data_in,
  input  logic [0:127] key_in,
  output logic [0:127] data_out,
  output logic         done
);
  logic   load, step, last_rnd;
  byte_t  rcon;
  block_t state_q, rkey_q, rnd_out, key_nx;

  aes_ctrl #(.NR(NUM_ROUNDS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .load     (load),
    .step     (step),
    .last_rnd (last_rnd),
    .rcon     (rcon),
    .done     (done)
  );

  aes_key_step u_key (
    .rk   (rkey_q),
    .rcon (rcon),
    .nk   (key_nx)
  );

  aes_round u_round (
    .st       (state_q),
    .rk       (key_nx),
    .last_rnd (last_rnd),
    .nx       (rnd_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      rkey_q  <= '0;
    end else if (load) begin
      state_q <= block_t'(data_in ^ key_in);
      rkey_q  <= block_t'(key_in);
    end else if (step) begin
      state_q <= rnd_out;
      rkey_q  <= key_nx;
    end
  end

  assign data_out = state_q;

  p_dout_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> $stable(data_out));
  p_dout_zero_before_job_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !done && !step && !$past(done) && !$past(step) && !$past(load) |-> data_out == '0);
endmodule

// File: tb/aes_iter_core_tb.sv
`timescale 1ns/1ps
module aes_iter_core_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [0:127] data_in = '0;
  logic [0:127] key_in = '0;
  logic [0:127] data_out;
  logic         done;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] sb_t [256];
  logic [63:0] rng = 64'h9e3779b97f4a7c15;

  always #4 clk = ~clk;

  aes_iter_core u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .data_in(data_in), .key_in(key_in),
    .data_out(data_out), .done(done)
  );

  function automatic logic [7:0] mul2(logic [7:0] b);
    return (b << 1) ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  // S-box from log/antilog tables with generator 3
  task automatic build_sbox();
    logic [7:0] ex [256];
    int lg [256];
    logic [7:0] e, inv, y;
    e = 8'h01;
    for (int i = 0; i < 255; i++) begin
      ex[i] = e;
      lg[e] = i;
      e = e ^ mul2(e);
    end
    for (int x = 0; x < 256; x++) begin
      inv = (x == 0) ? 8'h00 : ex[(255 - lg[x]) % 255];
      for (int b = 0; b < 8; b++)
        y[b] = inv[b] ^ inv[(b+4)%8] ^ inv[(b+5)%8] ^ inv[(b+6)%8]
               ^ inv[(b+7)%8] ^ ((8'h63 >> b) & 1'b1);
      sb_t[x] = y;
    end
  endtask

  function automatic logic [127:0] ref_enc(logic [127:0] k, logic [127:0] p);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0] s [16];
    logic [7:0] q [16];
    logic [7:0] rc;
    logic [127:0] out;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {sb_t[t[31:24]] ^ rc, sb_t[t[23:16]], sb_t[t[15:8]], sb_t[t[7:0]]};
        rc = mul2(rc);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int i = 0; i < 16; i++) s[i] = p[127-8*i -: 8] ^ w[i/4][31-8*(i%4) -: 8];
    for (int rd = 1; rd <= 10; rd++) begin
      for (int i = 0; i < 16; i++) q[i] = sb_t[s[i]];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) s[4*c+r] = q[4*((c+r)%4)+r];
      if (rd < 10)
        for (int c = 0; c < 4; c++) begin
          for (int r = 0; r < 4; r++) q[r] = s[4*c+r];
          for (int r = 0; r < 4; r++)
            s[4*c+r] = mul2(q[r]) ^ mul2(q[(r+1)%4]) ^ q[(r+1)%4] ^ q[(r+2)%4] ^ q[(r+3)%4];
        end
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ w[4*rd + i/4][31-8*(i%4) -: 8];
    end
    for (int i = 0; i < 16; i++) out[127-8*i -: 8] = s[i];
    return out;
  endfunction

  function automatic logic [127:0] next_rand();
    logic [127:0] v;
    for (int h = 0; h < 2; h++) begin
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 7);
      rng = rng ^ (rng << 17);
      v[64*h +: 64] = rng;
    end
    return v;
  endfunction

  task automatic chk(string rq, logic [127:0] act, logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // capture on one edge, done after the 10th edge that follows
  task automatic encrypt(logic [127:0] k, logic [127:0] p, bit poke, string rq);
    logic [127:0] exp;
    exp = ref_enc(k, p);
    @(negedge clk);
    start = 1'b1; data_in = p; key_in = k;
    @(posedge clk);
    @(negedge clk);
    start = poke;
    data_in = ~p; key_in = ~k;            // R2: ignored after capture
    chk("R7 done low after capture", {127'd0, done}, 128'd0);
    for (int i = 1; i <= 10; i++) begin
      @(posedge clk);
      @(negedge clk);
      start = poke && (i <= 5);           // R6: start while busy
      if (i == 9) chk("R3 done low at edge 9", {127'd0, done}, 128'd0);
      if (i == 10) begin
        chk("R3 done high at edge 10", {127'd0, done}, 128'd1);
        chk(rq, data_out, exp);
      end
    end
  endtask

  initial begin
    logic [127:0] held, k, p;
    build_sbox();
    repeat (3) @(negedge clk);
    chk("R1 done in reset", {127'd0, done}, 128'd0);
    chk("R1 data_out in reset", data_out, 128'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      data_in = next_rand();
      key_in = next_rand();
      chk("R2 idle without start", {127'd0, done}, 128'd0);
      chk("R1 data_out zero after reset", data_out, 128'd0);
    end

    encrypt(128'h000102030405060708090a0b0c0d0e0f,
            128'h00112233445566778899aabbccddeeff, 1'b0, "R4 standard vector");
    chk("R4 ciphertext constant", data_out, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    chk("R8 first byte at bits 0..7", {120'd0, data_out[0:7]}, 128'h69);
    chk("R8 last byte at bits 120..127", {120'd0, data_out[120:127]}, 128'h5a);

    held = data_out;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      data_in = next_rand();
      key_in = next_rand();
      chk("R7 done holds", {127'd0, done}, 128'd1);
      chk("R7 data_out holds", data_out, held);
    end

    encrypt(128'h2b7e151628aed2a6abf7158809cf4f3c,
            128'h3243f6a8885a308d313198a2e0370734, 1'b1, "R6 start pulses while busy");
    chk("R5 second known vector", data_out, 128'h3925841d02dc09fbdc118597196a0b32);
    encrypt(128'd0, 128'd0, 1'b0, "R5 all-zero inputs");
    chk("R5 zero vector", data_out, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e);
    encrypt({128{1'b1}}, {128{1'b1}}, 1'b0, "R5 all-ones inputs");

    for (int n = 0; n < 64; n++) begin
      k = next_rand();
      p = next_rand();
      encrypt(k, p, n[0], n[0] ? "R6 sweep with busy start" : "R5 sweep");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_fail++;
    n_run++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule